// File: doc/BRIEF.md
# Receive-side XON/XOFF flow-control detector

This block sits on the character stream between a UART receiver and its receive FIFO. Every completed received character enters on a valid/ready input. The block compares it against four programmed characters: two "stop" characters and two "go" characters. Depending on the configured mode, the block either swallows the character as a flow-control command or passes it on unchanged to the FIFO-side valid/ready output. A recognised stop command raises `tx_halt` toward the local transmitter. The transmitter is expected to finish the character it is currently shifting out and then pause. A recognised go command drops `tx_halt` again.

A 2-bit mode selects how matching works. It can be off, it can match single characters from the first pair or from the second pair, or it can require two characters in a row. In the two-character mode, a first character that might start a pair is held inside the block until the next character decides the outcome. Two further options sit alongside the mode. "Resume on any" lets any received character end a halt. "Special character" raises the interrupt flag when the second stop character passes through, without halting. The interrupt flag is a plain level output.

Stream rules: a character is taken on a cycle where `in_valid` and `in_ready` are both high. A character that is forwarded is taken only when `out_ready` is high, so back-pressure from the FIFO stalls the input. A character that is consumed as a command, or held as the first half of a pair, is taken at once, whatever the state of `out_ready`. `out_data` is the input character passed through with no added latency. The one exception is when a held character must be released: it is then presented on the output first, and the input waits.

Top module: `flowctl_rx_detector`

## Requirements
- R1: With `fc_mode` = 00, every received character is forwarded unchanged and `tx_halt` never rises.
- R2: With `fc_mode` = 01 the block matches `stop_a`/`go_a`, and with 10 it matches `stop_b`/`go_b`. A matching stop character sets `tx_halt` on the clock edge that accepts it, and a matching go character clears it. Both are consumed: they are accepted without regard to `out_ready`, and `out_valid` stays low for them.
- R3: With `fc_mode` = 11, a stop is recognised only as `stop_a` immediately followed by `stop_b`, and a go only as `go_a` immediately followed by `go_b`. Both characters are consumed. The first one is accepted and held with no output.
- R4: When a held first character is not completed by the next one, or when `fc_mode` leaves 11, the held character is presented first on the output, with `in_ready` low. After that, the new character is judged afresh, and it may itself start a new pair.
- R5: A recognised stop sets `xoff_irq` only when `xoff_ien` is high. A recognised go clears `xoff_irq`.
- R6: With `resume_any` high and `tx_halt` set, the next accepted character clears `tx_halt` and `xoff_irq` and never starts a pair. That character is consumed if it equals the first go character of the mode (`go_b` in mode 10, otherwise `go_a`) and is forwarded if it does not.
- R7: With `special_en` and `xoff_ien` both high, a forwarded input character equal to `stop_b` sets `xoff_irq`, leaves `tx_halt` unchanged, and is still forwarded.
- R8: A `stat_rd` pulse clears `xoff_irq` only when the flag was set by a special-character match. A flag set by a stop command survives the read.
- R9: A forwarded character appears on `out_data` in the same cycle. `in_ready` is low while `out_valid` is high and `out_ready` is low.
- R10: Synchronous active-high `rst` clears `tx_halt`, `xoff_irq` and any held first character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_mode | input | 2 | Matching mode: 00 off, 01 first pair, 10 second pair, 11 two in a row |
| resume_any | input | 1 | Any character ends a halt |
| special_en | input | 1 | Flag `stop_b` on forwarded characters |
| xoff_ien | input | 1 | Allow stop and special matches to set the flag |
| stat_rd | input | 1 | Interrupt-status read strobe |
| go_a | input | W | First go character |
| go_b | input | W | Second go character |
| stop_a | input | W | First stop character |
| stop_b | input | W | Second stop character |
| in_valid | input | 1 | Received character valid |
| in_data | input | W | Received character |
| in_ready | output | 1 | Character taken this cycle when high together with `in_valid` |
| out_valid | output | 1 | Character offered to the receive FIFO |
| out_data | output | W | Character to the receive FIFO |
| out_ready | input | 1 | FIFO can take a character |
| tx_halt | output | 1 | Transmitter must pause after its current character |
| xoff_irq | output | 1 | Stop interrupt flag |

## Verification
A wrong halt state shows on `tx_halt` one clock after the deciding character is accepted. A lost or stale held character shows on the very next input character: it appears as a missing or extra byte, or as a wrong byte order on `out_data`. A stuck interrupt source shows on the first `stat_rd` pulse, because the flag either drops or stays up wrongly. Sweeping every character value through each mode brings every comparator mismatch to the output within one character.

// File: rtl/flowctl_rx_pkg.sv
package flowctl_rx_pkg;

  typedef enum logic [1:0] {
    FC_OFF   = 2'b00,
    FC_PAIRA = 2'b01,
    FC_PAIRB = 2'b10,
    FC_SEQ   = 2'b11
  } fc_mode_e;

  typedef enum logic {
    HK_STOP = 1'b0,
    HK_GO   = 1'b1
  } held_kind_e;

  typedef struct packed {
    logic       hit_stop;
    logic       hit_go;
    logic       start_hold;
    held_kind_e start_kind;
    logic       pair_broken;
    logic       is_special;
  } verdict_t;

endpackage

// File: rtl/flowctl_rx_classify.sv
module flowctl_rx_classify
  import flowctl_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  fc_mode_e   mode,
  input  logic [W-1:0] ch,
  input  logic [W-1:0] go_a,
  input  logic [W-1:0] go_b,
  input  logic [W-1:0] stop_a,
  input  logic [W-1:0] stop_b,
  input  logic       held_valid,
  input  held_kind_e held_kind,
  output verdict_t   verdict
);

  always_comb begin
    verdict            = '0;
    verdict.start_kind = HK_STOP;
    verdict.is_special = (ch == stop_b);
    case (mode)
      FC_PAIRA: begin
        verdict.hit_stop = (ch == stop_a);
        verdict.hit_go   = (ch != stop_a) && (ch == go_a);
      end
      FC_PAIRB: begin
        verdict.hit_stop = (ch == stop_b);
        verdict.hit_go   = (ch != stop_b) && (ch == go_b);
      end
      FC_SEQ: begin
        if (held_valid) begin
          verdict.hit_stop    = (held_kind == HK_STOP) && (ch == stop_b);
          verdict.hit_go      = (held_kind == HK_GO) && (ch == go_b);
          verdict.pair_broken = !(verdict.hit_stop || verdict.hit_go);
        end else if (ch == stop_a) begin
          verdict.start_hold = 1'b1;
          verdict.start_kind = HK_STOP;
        end else if (ch == go_a) begin
          verdict.start_hold = 1'b1;
          verdict.start_kind = HK_GO;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flowctl_rx_hold.sv
module flowctl_rx_hold
  import flowctl_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  held_kind_e   load_kind,
  input  logic [W-1:0] load_data,
  input  logic         drop,
  output logic         held_valid,
  output held_kind_e   held_kind,
  output logic [W-1:0] held_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      held_kind  <= HK_STOP;
      held_data  <= '0;
    end else if (load) begin
      held_valid <= 1'b1;
      held_kind  <= load_kind;
      held_data  <= load_data;
    end else if (drop) begin
      held_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/flowctl_rx_status.sv
module flowctl_rx_status (
  input  logic clk,
  input  logic rst,
  input  logic stop_seen,
  input  logic go_seen,
  input  logic special_seen,
  input  logic ien,
  input  logic stat_rd,
  output logic tx_halt,
  output logic xoff_irq
);

  logic from_special;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_halt <= 1'b0;
    end else if (stop_seen) begin
      tx_halt <= 1'b1;
    end else if (go_seen) begin
      tx_halt <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xoff_irq     <= 1'b0;
      from_special <= 1'b0;
    end else if (stop_seen) begin
      if (ien) begin
        xoff_irq     <= 1'b1;
        from_special <= 1'b0;
      end
    end else if (go_seen) begin
      xoff_irq     <= 1'b0;
      from_special <= 1'b0;
    end else if (special_seen && ien && !xoff_irq) begin
      xoff_irq     <= 1'b1;
      from_special <= 1'b1;
    end else if (stat_rd && from_special && !special_seen) begin
      xoff_irq     <= 1'b0;
      from_special <= 1'b0;
    end
  end

endmodule

// File: rtl/flowctl_rx_detector.sv
module flowctl_rx_detector
  import flowctl_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   fc_mode,
  input  logic         resume_any,
  input  logic         special_en,
  input  logic         xoff_ien,
  input  logic         stat_rd,
  input  logic [W-1:0] go_a,
  input  logic [W-1:0] go_b,
  input  logic [W-1:0] stop_a,
  input  logic [W-1:0] stop_b,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic         tx_halt,
  output logic         xoff_irq
);

  fc_mode_e     mode;
  verdict_t     verdict;
  logic         held_valid;
  held_kind_e   held_kind;
  logic [W-1:0] held_data;
  logic         release_held;
  logic         any_mode;
  logic         any_consume;
  logic [W-1:0] first_go;
  logic         act_consume;
  logic         act_hold;
  logic         act_fwd;
  logic         accept;

  assign mode = fc_mode_e'(fc_mode);

  flowctl_rx_classify #(.W(W)) u_classify (
    .mode       (mode),
    .ch         (in_data),
    .go_a       (go_a),
    .go_b       (go_b),
    .stop_a     (stop_a),
    .stop_b     (stop_b),
    .held_valid (held_valid),
    .held_kind  (held_kind),
    .verdict    (verdict)
  );

  // A held first character leaves when the pair cannot complete.
  assign release_held = held_valid &&
                        ((mode != FC_SEQ) || (in_valid && verdict.pair_broken));

  assign any_mode    = tx_halt && resume_any;
  assign first_go    = (mode == FC_PAIRB) ? go_b : go_a;
  assign any_consume = (mode != FC_OFF) && (in_data == first_go);

  assign act_consume = any_mode ? any_consume : (verdict.hit_stop || verdict.hit_go);
  assign act_hold    = !any_mode && verdict.start_hold;
  assign act_fwd     = !act_consume && !act_hold;

  assign in_ready  = !release_held && (act_fwd ? out_ready : 1'b1);
  assign accept    = in_valid && in_ready;
  assign out_valid = release_held || (in_valid && act_fwd);
  assign out_data  = release_held ? held_data : in_data;

  flowctl_rx_hold #(.W(W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .load       (accept && act_hold),
    .load_kind  (verdict.start_kind),
    .load_data  (in_data),
    .drop       ((release_held && out_ready) || (accept && held_valid)),
    .held_valid (held_valid),
    .held_kind  (held_kind),
    .held_data  (held_data)
  );

  flowctl_rx_status u_status (
    .clk          (clk),
    .rst          (rst),
    .stop_seen    (accept && !any_mode && verdict.hit_stop),
    .go_seen      (accept && (any_mode || (!verdict.hit_stop && verdict.hit_go))),
    .special_seen (accept && act_fwd && special_en && verdict.is_special),
    .ien          (xoff_ien),
    .stat_rd      (stat_rd),
    .tx_halt      (tx_halt),
    .xoff_irq     (xoff_irq)
  );

endmodule

// File: rtl/flowctl_rx_checker.sv
module flowctl_rx_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   fc_mode,
  input logic         xoff_ien,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         in_ready,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_ready,
  input logic         tx_halt,
  input logic         xoff_irq
);

  AST_STALL_ON_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && in_valid && in_ready) |-> (out_data == in_data)); // R9

  AST_HALT_FROM_COMMAND: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_halt) |-> $past(in_valid && in_ready && !out_valid)); // R2

  AST_OFF_NEVER_HALTS: assert property (@(posedge clk) disable iff (rst)
    (fc_mode == 2'b00 && !tx_halt) |=> !tx_halt); // R1

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(xoff_irq) |-> $past(xoff_ien)); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!tx_halt && !xoff_irq)); // R10

endmodule

bind flowctl_rx_detector flowctl_rx_checker #(.W(W)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .fc_mode   (fc_mode),
  .xoff_ien  (xoff_ien),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .tx_halt   (tx_halt),
  .xoff_irq  (xoff_irq)
);

// File: tb/flowctl_rx_detector_test.sv
module flowctl_rx_detector_test;

  localparam logic [7:0] GA = 8'h11;
  localparam logic [7:0] SA = 8'h13;
  localparam logic [7:0] GB = 8'h91;
  localparam logic [7:0] SB = 8'h93;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] fc_mode = 2'b00;
  logic       resume_any = 1'b0;
  logic       special_en = 1'b0;
  logic       xoff_ien = 1'b1;
  logic       stat_rd = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;
  logic       tx_halt;
  logic       xoff_irq;

  int errors = 0;
  int checks = 0;
  int sn;
  logic [7:0] sd0, sd1;
  logic acc;

  always #5 clk = ~clk;

  flowctl_rx_detector #(.W(8)) uut (
    .clk(clk), .rst(rst), .fc_mode(fc_mode), .resume_any(resume_any),
    .special_en(special_en), .xoff_ien(xoff_ien), .stat_rd(stat_rd),
    .go_a(GA), .go_b(GB), .stop_a(SA), .stop_b(SB),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .tx_halt(tx_halt), .xoff_irq(xoff_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Present one character until it is taken; record output transfers.
  task automatic step(input logic [7:0] c);
    sn = 0;
    @(negedge clk);
    in_data  = c;
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      if (out_valid && out_ready) begin
        if (sn == 0) sd0 = out_data; else sd1 = out_data;
        sn++;
      end
      acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic pulse_rst;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic pulse_rd;
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic halted, irq_exp;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10", "reset tx_halt", tx_halt, 0);
    chk("R10", "reset irq", xoff_irq, 0);
    chk("R10", "reset out_valid", out_valid, 0);
    chk("R10", "reset in_ready", in_ready, 1);

    // R1 and R7: mode off, special character flagged and forwarded
    fc_mode = 2'b00; special_en = 1'b1; irq_exp = 1'b0;
    for (int v = 0; v < 256; v++) begin
      step(8'(v));
      if (v == SB) irq_exp = 1'b1;
      chk("R1", "off count", sn, 1);
      chk("R1", "off data", sd0, v);
      chk("R1", "off halt", tx_halt, 0);
      chk("R7", "special irq", xoff_irq, irq_exp);
    end
    pulse_rd();
    chk("R8", "special irq cleared by read", xoff_irq, 0);
    special_en = 1'b0;

    // R2 and R5: single-character modes
    for (int m = 1; m <= 2; m++) begin
      logic [7:0] s, g;
      s = (m == 1) ? SA : SB;
      g = (m == 1) ? GA : GB;
      fc_mode = 2'(m);
      halted = 1'b0;
      for (int v = 0; v < 256; v++) begin
        step(8'(v));
        if (v == s) halted = 1'b1;
        else if (v == g) halted = 1'b0;
        chk("R2", "single count", sn, (v == s || v == g) ? 0 : 1);
        if (sn == 1) chk("R2", "single data", sd0, v);
        chk("R2", "single halt", tx_halt, halted);
        chk("R5", "single irq", xoff_irq, halted);
      end
      pulse_rd();
      chk("R8", "stop irq survives read", xoff_irq, 1);
      step(g);
      chk("R2", "go releases", tx_halt, 0);
      chk("R5", "go clears irq", xoff_irq, 0);
    end

    // R3 and R4: two-character sequence
    fc_mode = 2'b11;
    for (int v = 0; v < 256; v++) begin
      if (v == SA || v == GA) continue;
      step(SA);
      chk("R3", "first char held", sn, 0);
      step(8'(v));
      if (v == SB) begin
        chk("R3", "pair consumed", sn, 0);
        chk("R3", "pair halts", tx_halt, 1);
        step(GA);
        chk("R3", "go first held", sn, 0);
        chk("R3", "go first keeps halt", tx_halt, 1);
        step(GB);
        chk("R3", "go pair consumed", sn, 0);
        chk("R3", "go pair releases", tx_halt, 0);
      end else begin
        chk("R4", "broken count", sn, 2);
        chk("R4", "broken held first", sd0, SA);
        chk("R4", "broken then new", sd1, v);
        chk("R4", "broken no halt", tx_halt, 0);
      end
    end
    step(SA);
    step(SA);
    chk("R4", "restart count", sn, 1);
    chk("R4", "restart data", sd0, SA);
    step(SB);
    chk("R4", "restart completes", tx_halt, 1);
    step(GA); step(GB);
    chk("R3", "released", tx_halt, 0);
    step(SA);
    @(negedge clk); fc_mode = 2'b00; #1;
    chk("R4", "mode leave flush valid", out_valid, 1);
    chk("R4", "mode leave flush data", out_data, SA);
    @(negedge clk); #1;
    chk("R4", "flush done", out_valid, 0);

    // R9: back-pressure
    fc_mode = 2'b01; out_ready = 1'b0;
    @(negedge clk); in_data = 8'h41; in_valid = 1'b1; #1;
    chk("R9", "stall in_ready", in_ready, 0);
    chk("R9", "stall out_valid", out_valid, 1);
    chk("R9", "stall data", out_data, 8'h41);
    in_data = SA; #1;
    chk("R9", "command taken under backpressure", in_ready, 1);
    chk("R9", "command not offered", out_valid, 0);
    @(negedge clk); in_valid = 1'b0; #1;
    chk("R2", "halt under backpressure", tx_halt, 1);
    out_ready = 1'b1;
    step(GA);

    // R5: enable low
    xoff_ien = 1'b0;
    step(SA);
    chk("R5", "halt without enable", tx_halt, 1);
    chk("R5", "no irq without enable", xoff_irq, 0);
    step(GA);
    xoff_ien = 1'b1;

    // R6: resume on any
    resume_any = 1'b1;
    step(SA);
    step(8'h41);
    chk("R6", "any forwarded", sn, 1);
    chk("R6", "any releases", tx_halt, 0);
    chk("R6", "any clears irq", xoff_irq, 0);
    step(SA);
    step(GA);
    chk("R6", "go consumed", sn, 0);
    chk("R6", "go releases", tx_halt, 0);
    fc_mode = 2'b11;
    step(SA); step(SB);
    chk("R6", "seq halted", tx_halt, 1);
    step(GA);
    chk("R6", "first go consumed", sn, 0);
    chk("R6", "first go releases", tx_halt, 0);
    step(GB);
    chk("R6", "second go forwarded", sn, 1);
    chk("R6", "second go data", sd0, GB);
    resume_any = 1'b0;

    // R10: reset mid-operation
    step(SA); step(SB); step(SA);
    pulse_rst();
    #1;
    chk("R10", "rst clears halt", tx_halt, 0);
    chk("R10", "rst clears irq", xoff_irq, 0);
    step(SB);
    chk("R10", "held char dropped", sn, 1);
    chk("R10", "lone stop_b forwarded", sd0, SB);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule